// File: doc/BRIEF.md
# Double-Buffered Serial Byte Transmitter

This block sends bytes as asynchronous serial frames. A one-byte holding stage sits in front of a shift stage. Software watches the ready flag `tx_ready` and, while it is high, places a byte on `wr_data` and pulses `wr_en`. As soon as the shift stage is free, the byte moves from the holding stage into it. The shift stage then sends a low start bit, eight data bits with the least significant bit first, and a high stop bit. It advances one bit each time the external `baud_tick` pulses.

The handoff between the two stages is atomic. The holding stage is marked empty on the same clock edge that its byte enters the shift stage, so no byte can be handed over twice. A write can land on the same edge that the stop bit ends, and it still yields exactly one frame. A write that arrives while the holding stage is full is dropped and sets a sticky overrun flag.

The shift stage is a four-state machine:

| State | Line level | Transitions |
|---|---|---|
| IDLE | high | *load*: IDLE -> START when the holding stage is full |
| START | low | *start done*: START -> DATA on a tick |
| DATA | current data bit | *next bit*: DATA -> DATA on a tick; *last bit*: DATA -> STOP on the tick that ends bit 7 |
| STOP | high | *chain*: STOP -> START on a tick with a byte waiting; *finish*: STOP -> IDLE on a tick with none waiting |

Top module: `uart_tx_dbuf`

## Requirements
- R1: A frame is one low start bit, then data bits 0 through 7 in that order, then one high stop bit. The machine leaves START, DATA and STOP only on a cycle where `baud_tick` is high. Sampled on the ten tick cycles of a frame, `txd` therefore reads 0, d0..d7, 1.
- R2: After reset, `tx_ready` = 1, `tx_idle` = 1, `txd` = 1 and `overrun` = 0. `tx_ready` is high exactly when the holding stage is empty, and a write is accepted exactly when `tx_ready` is high on its clock edge.
- R3: A write accepted on edge k while the shift stage is idle drives `tx_ready` low after edge k. `txd` goes low (start bit) after edge k+1, and `tx_ready` is high again after edge k+1.
- R4: The holding stage is emptied on the same edge its byte enters the shift stage. Every accepted byte is sent exactly once, in write order.
- R5: A write on the edge where the stop bit ends, with the holding stage empty, is accepted and yields exactly one frame of that byte.
- R6: If a byte is waiting when the stop bit ends, its start bit begins on the next cycle, with no idle cycle between the frames.
- R7: A write while `tx_ready` is low is ignored: the held byte is kept and no extra frame appears. It sets `overrun`, which stays set until reset.
- R8: `tx_idle` is high only when no frame is in progress and the holding stage is empty.
- R9: `txd` stays high whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial line |
| tx_ready | output | 1 | Holding stage empty; a write will be accepted |
| tx_idle | output | 1 | No frame in progress and nothing waiting |
| overrun | output | 1 | Sticky: a write was dropped because the holding stage was full |

## Verification
`tx_ready` falls one edge after an accepted write. The start bit appears one edge after that when the line was idle, or one edge after the stop-ending tick when frames are chained. Each frame bit is taken on the cycle where `baud_tick` is high, just before the edge that moves the machine on. The bench drives and samples on the falling clock edge. It reads the ready flag, the line and the idle flag exactly those numbers of falling edges after a write or after the tenth tick of a frame. A frame monitor compares every decoded byte, in order, with the queue of bytes the model predicted would be accepted. Duplicated frames and lost frames both appear as mismatches or as leftover queue entries.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/uart_tx_hold.sv
// One-byte holding stage: accepts a write only when empty, empties on take.
module uart_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data,
    output logic          overrun
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full    <= 1'b0;
            data    <= '0;
            overrun <= 1'b0;
        end else begin
            if (wr_en && full) begin
                overrun <= 1'b1;
            end
            if (wr_en && !full) begin
                full <= 1'b1;
                data <= wr_data;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

    // R4: a taken byte leaves the holding stage on the same edge
    p_take_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !full);
    // R7: overrun is sticky
    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R7: a rejected write leaves the held byte untouched
    p_full_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !take) |=> (full && $stable(data)));
endmodule

// File: rtl/uart_tx_shift.sv
// Shift stage: frame state machine driven by baud ticks.
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          have_byte,
    input  logic [DW-1:0] byte_in,
    output logic          take,
    output logic          txd,
    output logic          busy
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    tx_state_e     state, state_nx;
    logic [DW-1:0] shreg;
    logic [CW-1:0] bit_cnt;

    // next state and handoff
    always_comb begin
        state_nx = state;
        take     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (have_byte) begin
                    state_nx = ST_START;
                    take     = 1'b1;
                end
            end
            ST_START: begin
                if (baud_tick) state_nx = ST_DATA;
            end
            ST_DATA: begin
                if (baud_tick && bit_cnt == LAST) state_nx = ST_STOP;
            end
            ST_STOP: begin
                if (baud_tick) begin
                    if (have_byte) begin
                        state_nx = ST_START;
                        take     = 1'b1;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
        end else begin
            state <= state_nx;
            if (take) begin
                shreg   <= byte_in;
                bit_cnt <= '0;
            end else if (state == ST_DATA && baud_tick) begin
                shreg   <= shreg >> 1;
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        txd  = 1'b1;
        busy = 1'b1;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_START: txd  = 1'b0;
            ST_DATA:  txd  = shreg[0];
            ST_STOP:  txd  = 1'b1;
        endcase
    end

    // R1: a frame in progress moves only on a tick
    p_tick_paced_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !baud_tick) |=> (state == $past(state)));
    // R3: an idle stage picks up a waiting byte on the next edge
    p_idle_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && have_byte) |=> (state == ST_START));
    // R6: a waiting byte chains directly after the stop bit
    p_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && baud_tick && have_byte) |=> (state == ST_START));
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          txd,
    output logic          tx_ready,
    output logic          tx_idle,
    output logic          overrun
);
    logic          hold_full;
    logic [DW-1:0] hold_data;
    logic          take;
    logic          busy;

    uart_tx_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data),
        .overrun (overrun)
    );

    uart_tx_shift #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .have_byte (hold_full),
        .byte_in   (hold_data),
        .take      (take),
        .txd       (txd),
        .busy      (busy)
    );

    assign tx_ready = !hold_full;
    assign tx_idle  = !busy && !hold_full;

    // R9: nothing in flight means a high line and a free holding stage
    p_idle_line_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> (txd && tx_ready));
    // R2: an accepted write makes the holding stage full on the next edge
    p_accept_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_ready) |=> !tx_ready);
endmodule

// File: tb/uart_tx_dbuf_test.sv
module uart_tx_dbuf_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, tx_ready, tx_idle, overrun;

    int checks = 0;
    int errors = 0;
    int frames = 0;
    int tick_cnt = 0;
    bit done = 1'b0;
    bit in_frame = 1'b0;
    int bit_idx = 0;
    logic [9:0] fr;
    logic [7:0] exp_q[$];

    uart_tx_dbuf uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .txd(txd), .tx_ready(tx_ready),
        .tx_idle(tx_idle), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        tick_cnt  <= (tick_cnt == DIV-1) ? 0 : tick_cnt + 1;
        baud_tick <= (tick_cnt == DIV-2);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit frame_ok(input logic [9:0] f);
        return (f[0] == 1'b0) && (f[9] == 1'b1);
    endfunction

    // frame monitor: one sample per tick cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (!in_frame && txd == 1'b0) begin
                in_frame = 1'b1;
                bit_idx  = 0;
            end
            if (in_frame && baud_tick) begin
                fr[bit_idx] = txd;
                bit_idx++;
                if (bit_idx == 10) begin
                    in_frame = 1'b0;
                    frames++;
                    chk(frame_ok(fr), "R1 start/stop", int'(fr), 10'h200);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R4 unexpected frame", int'(fr[8:1]), 0);
                    end else begin
                        chk(fr[8:1] == exp_q[0], "R4 frame data", int'(fr[8:1]), int'(exp_q[0]));
                        void'(exp_q.pop_front());
                    end
                end
            end
        end
    end

    // write on the next edge; model acceptance from the ready flag (R2)
    task automatic do_write(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        if (tx_ready) exp_q.push_back(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // return at the negedge of the 10th tick of the next frame (stop-bit end)
    task automatic wait_stop_tick();
        int cnt;
        do @(negedge clk); while (txd !== 1'b0);
        cnt = baud_tick ? 1 : 0;
        while (cnt < 10) begin
            @(negedge clk);
            if (baud_tick) cnt++;
        end
    endtask

    task automatic wait_quiet();
        do @(negedge clk); while (!(tx_idle && !in_frame));
        repeat (3 * DIV) @(negedge clk);
    endtask

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 / R8 / R9 reset state
        chk(txd == 1'b1, "R9 idle line", txd, 1);
        chk(tx_ready == 1'b1, "R2 ready after reset", tx_ready, 1);
        chk(tx_idle == 1'b1, "R8 idle after reset", tx_idle, 1);
        chk(overrun == 1'b0, "R2 overrun after reset", overrun, 0);

        // R3 single write into idle
        do_write(8'hA5);
        chk(tx_ready == 1'b0, "R3 ready low after write", tx_ready, 0);
        chk(tx_idle == 1'b0, "R8 not idle with byte held", tx_idle, 0);
        chk(txd == 1'b1, "R3 line still high", txd, 1);
        @(negedge clk);
        chk(txd == 1'b0, "R3 start bit", txd, 0);
        chk(tx_ready == 1'b1, "R3 ready back", tx_ready, 1);
        wait_quiet();
        chk(overrun == 1'b0, "R7 no false overrun", overrun, 0);
        chk(txd == 1'b1, "R9 line high after frame", txd, 1);

        // R5 write on the stop-ending edge
        f0 = frames;
        do_write(8'h3C);
        wait_stop_tick();
        chk(tx_ready == 1'b1, "R5 ready at stop end", tx_ready, 1);
        do_write(8'hC3);
        wait_quiet();
        chk(frames - f0 == 2, "R5 exactly one extra frame", frames - f0, 2);
        chk(exp_q.size() == 0, "R5 nothing left", exp_q.size(), 0);

        // R6 back-to-back chaining
        do_write(8'h81);
        do @(negedge clk); while (!tx_ready);
        do_write(8'h7E);
        wait_stop_tick();
        chk(tx_idle == 1'b0, "R8 busy with byte waiting", tx_idle, 0);
        @(negedge clk);
        chk(txd == 1'b0, "R6 start right after stop", txd, 0);
        wait_quiet();

        // R7 writes while full
        f0 = frames;
        do_write(8'h11);
        do_write(8'hEE);
        chk(overrun == 1'b1, "R7 overrun set", overrun, 1);
        do_write(8'h22);
        do_write(8'hDD);
        wait_quiet();
        chk(frames - f0 == 2, "R7 rejected writes not sent", frames - f0, 2);
        chk(overrun == 1'b1, "R7 overrun sticky", overrun, 1);

        // random traffic
        void'($urandom(32'd2718));
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 8 == 0) do_write(8'($urandom));
            else @(negedge clk);
            if (tx_idle && txd !== 1'b1)
                chk(1'b0, "R9 idle line random", txd, 1);
        end
        wait_quiet();
        chk(exp_q.size() == 0, "R4 all bytes sent once", exp_q.size(), 0);
        chk(tx_idle == 1'b1 && tx_ready == 1'b1, "R8 idle at end", tx_idle, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule